// File: doc/BRIEF.md
# Error Exception Capture Unit

This block holds the two pieces of machine state that a processor needs when it takes an error-level exception. The first is a 32-bit cache error status word. It records whether the failing reference was an instruction or a data access, which cache field failed parity, whether a system bus error was reported, and which cache index was involved. The second is a 32-bit error return address. It records where execution resumes once the error handler finishes.

The parity checker reports an error as a single-cycle event. Exception control sends a single-cycle trigger for each error-level cause: cache error, cold reset, soft reset or NMI. The trigger carries the faulting PC, a delay-slot flag and the address of the preceding branch. A current error-level status bit, driven from outside, keeps a pending error from being lost. While this bit is 1, the return address is held. A data error that follows an unfinished instruction error only raises a chained flag, so the original report survives. Software reads both registers through a small select-based port and can rewrite them. Only cache memory is covered, and errors are reported without being corrected.

Top module: `err_capture_unit`

## Requirements
- R1: After reset, both the status word (select 0) and the return address (select 1) read as 0.
- R2: A cache error event that is not chained loads the status word one clock later with these fields: bit 31 = reference type (0 instruction, 1 data), bit 30 = data-field parity error, bit 29 = tag-field parity error, bit 27 = system bus error, bits 11:0 = cache index. Bit 25 (chained) is cleared.
- R3: The reserved bits of the status word (every bit outside 31, 30, 29, 27, 25 and 11:0) always read as 0. Software writes to those bits have no effect.
- R4: An instruction error is pending when the error level is 1, the stored reference type is 0, and at least one of bits 30, 29 and 27 is set. A data-reference cache error that arrives while an instruction error is pending sets bit 25 and leaves every other status bit unchanged.
- R5: A data-reference error arriving while the error level is 0 is not chained. A data-reference error arriving while the stored reference type is 1 is not chained. In both cases the whole status word is overwritten and bit 25 is cleared.
- R6: An exception trigger that arrives while the error level is 0 and the delay-slot flag is 0 loads the faulting PC into the return address one clock later.
- R7: An exception trigger that arrives while the error level is 0 and the delay-slot flag is 1 loads the preceding branch address instead. The register has no delay-slot bit.
- R8: While the error level is 1, exception triggers leave the return address unchanged.
- R9: A software write (write enable with select 0 or 1) updates the selected register on the next clock. The return address takes all 32 bits whatever the error level. The read data shows the register picked by the select input.
- R10: When a hardware capture and a software write target the same register in the same cycle, the captured value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cerr_valid | input | 1 | Cache parity error event, one cycle |
| cerr_is_data | input | 1 | Reference type of the error: 0 instruction, 1 data |
| cerr_data_fld | input | 1 | Parity failure in the data field |
| cerr_tag_fld | input | 1 | Parity failure in the tag field |
| cerr_bus | input | 1 | System bus error flag |
| cerr_index | input | IDX_W | Cache index of the failing line |
| exc_valid | input | 1 | Error-level exception trigger, one cycle |
| exc_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_pc | input | XLEN | Virtual address of the faulting instruction |
| exc_branch_pc | input | XLEN | Address of the preceding branch or jump |
| erl | input | 1 | Current error-level status bit |
| reg_we | input | 1 | Software write strobe |
| reg_sel | input | 1 | Register select: 0 status word, 1 return address |
| reg_wdata | input | XLEN | Software write data |
| reg_rdata | output | XLEN | Read data for the selected register |

## Verification
Both registers are visible through the read port, so any bad internal state shows at the ports on the first read after the clock edge that loaded it. A wrong pending-error decision shows up as the chained bit in the wrong state. It can also show up as an overwritten index or reference type where the original fields should have stayed. A leak through the error-level freeze shows as a return address that differs from the value captured before the bit was raised. The freeze and chaining cases are checked only on later reads that are separated from the event by idle cycles, which shows the stored state is held and not just passed through for one cycle.

// File: rtl/err_capture_unit.sv
module err_capture_unit #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cerr_valid,
  input  logic             cerr_is_data,
  input  logic             cerr_data_fld,
  input  logic             cerr_tag_fld,
  input  logic             cerr_bus,
  input  logic [IDX_W-1:0] cerr_index,
  input  logic             exc_valid,
  input  logic             exc_in_delay,
  input  logic [XLEN-1:0]  exc_pc,
  input  logic [XLEN-1:0]  exc_branch_pc,
  input  logic             erl,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [XLEN-1:0]  reg_wdata,
  output logic [XLEN-1:0]  reg_rdata
);
  localparam int P_REF = 31;
  localparam int P_ED  = 30;
  localparam int P_ET  = 29;
  localparam int P_EE  = 27;
  localparam int P_EB  = 25;

  logic             c_ref, c_ed, c_et, c_ee, c_eb;
  logic [IDX_W-1:0] c_idx;
  logic [XLEN-1:0]  epc_q;
  logic [XLEN-1:0]  cer_word;

  wire pending = erl && !c_ref && (c_ed || c_et || c_ee);
  wire chain   = cerr_valid && cerr_is_data && pending;

  always_comb begin
    cer_word          = '0;
    cer_word[P_REF]   = c_ref;
    cer_word[P_ED]    = c_ed;
    cer_word[P_ET]    = c_et;
    cer_word[P_EE]    = c_ee;
    cer_word[P_EB]    = c_eb;
    cer_word[IDX_W-1:0] = c_idx;
  end

  assign reg_rdata = reg_sel ? epc_q : cer_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {c_ref, c_ed, c_et, c_ee, c_eb} <= '0;
      c_idx <= '0;
    end else if (chain) begin
      c_eb <= 1'b1;
    end else if (cerr_valid) begin
      c_ref <= cerr_is_data;
      c_ed  <= cerr_data_fld;
      c_et  <= cerr_tag_fld;
      c_ee  <= cerr_bus;
      c_eb  <= 1'b0;
      c_idx <= cerr_index;
    end else if (reg_we && !reg_sel) begin
      c_ref <= reg_wdata[P_REF];
      c_ed  <= reg_wdata[P_ED];
      c_et  <= reg_wdata[P_ET];
      c_ee  <= reg_wdata[P_EE];
      c_eb  <= reg_wdata[P_EB];
      c_idx <= reg_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      epc_q <= '0;
    else if (exc_valid && !erl)
      epc_q <= exc_in_delay ? exc_branch_pc : exc_pc;
    else if (reg_we && reg_sel)
      epc_q <= reg_wdata;
  end
endmodule

// File: rtl/err_capture_chk.sv
module err_capture_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cerr_valid,
  input logic             cerr_is_data,
  input logic [IDX_W-1:0] cerr_index,
  input logic             exc_valid,
  input logic             exc_in_delay,
  input logic [XLEN-1:0]  exc_pc,
  input logic [XLEN-1:0]  exc_branch_pc,
  input logic             erl,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [XLEN-1:0]  reg_rdata,
  input logic             c_ref,
  input logic             c_ed,
  input logic             c_et,
  input logic             c_ee,
  input logic             c_eb,
  input logic [IDX_W-1:0] c_idx,
  input logic [XLEN-1:0]  epc_q
);
  localparam logic [XLEN-1:0] LIVE = {{(XLEN-32){1'b0}}, 32'hEA00_0000} | {{(XLEN-IDX_W){1'b0}}, {IDX_W{1'b1}}};

  wire pend_now = erl && !c_ref && (c_ed || c_et || c_ee);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> ((reg_rdata & ~LIVE) == '0));

  a_r4_chain_keeps_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cerr_valid && cerr_is_data && pend_now) |=> (c_eb && !c_ref && $stable(c_idx) && $stable(c_ed)));

  a_r2_capture_index: assert property (@(posedge clk) disable iff (!rst_n)
    (cerr_valid && !(cerr_is_data && pend_now)) |=> (c_idx == $past(cerr_index) && !c_eb));

  a_r8_epc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (erl && !(reg_we && reg_sel)) |=> $stable(epc_q));

  a_r6_epc_load_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !erl && !exc_in_delay) |=> (epc_q == $past(exc_pc)));

  a_r7_epc_load_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !erl && exc_in_delay) |=> (epc_q == $past(exc_branch_pc)));
endmodule

bind err_capture_unit err_capture_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cerr_valid(cerr_valid), .cerr_is_data(cerr_is_data),
  .cerr_index(cerr_index), .exc_valid(exc_valid), .exc_in_delay(exc_in_delay),
  .exc_pc(exc_pc), .exc_branch_pc(exc_branch_pc), .erl(erl), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata), .c_ref(c_ref), .c_ed(c_ed), .c_et(c_et),
  .c_ee(c_ee), .c_eb(c_eb), .c_idx(c_idx), .epc_q(epc_q)
);

// File: tb/err_capture_unit_tb.sv
`timescale 1ns/1ps
module err_capture_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        cerr_valid = 0, cerr_is_data = 0, cerr_data_fld = 0, cerr_tag_fld = 0, cerr_bus = 0;
  logic [11:0] cerr_index = '0;
  logic        exc_valid = 0, exc_in_delay = 0;
  logic [31:0] exc_pc = '0, exc_branch_pc = '0;
  logic        erl = 0, reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  typedef struct { logic sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  item_t it;

  always #2 clk = ~clk;

  err_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cerr_valid(cerr_valid), .cerr_is_data(cerr_is_data),
    .cerr_data_fld(cerr_data_fld), .cerr_tag_fld(cerr_tag_fld), .cerr_bus(cerr_bus),
    .cerr_index(cerr_index), .exc_valid(exc_valid), .exc_in_delay(exc_in_delay),
    .exc_pc(exc_pc), .exc_branch_pc(exc_branch_pc), .erl(erl), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      vectors++;
      if (reg_rdata !== it.exp) begin
        miscompares++;
        $display("FAIL %s: sel=%0d actual=%h expected=%h", it.tag, it.sel, reg_rdata, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic s, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_sel = s;
    q.push_back('{s, e, t});
    @(posedge clk);
  endtask

  task automatic cache_evt(input logic d, input logic ed, input logic et, input logic ee, input logic [11:0] ix);
    @(negedge clk);
    cerr_valid = 1; cerr_is_data = d; cerr_data_fld = ed; cerr_tag_fld = et; cerr_bus = ee; cerr_index = ix;
    @(negedge clk);
    cerr_valid = 0; cerr_is_data = 0; cerr_data_fld = 0; cerr_tag_fld = 0; cerr_bus = 0;
  endtask

  task automatic exc_evt(input logic [31:0] pc, input logic dly, input logic [31:0] br);
    @(negedge clk);
    exc_valid = 1; exc_pc = pc; exc_in_delay = dly; exc_branch_pc = br;
    @(negedge clk);
    exc_valid = 0; exc_in_delay = 0;
  endtask

  task automatic sw_write(input logic s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_rd(0, 32'h0, "R1 status after reset");
    expect_rd(1, 32'h0, "R1 return address after reset");

    cache_evt(0, 0, 1, 0, 12'h123);
    expect_rd(0, 32'h2000_0123, "R2 tag error capture");

    sw_write(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'hEA00_0FFF, "R3 reserved bits ignored on write (R9)");
    sw_write(0, 32'h0);
    expect_rd(0, 32'h0, "R9 status cleared by software");

    erl = 1;
    cache_evt(0, 1, 0, 0, 12'h0AB);
    expect_rd(0, 32'h4000_00AB, "R2 instruction data-field error");
    cache_evt(1, 1, 0, 0, 12'h555);
    expect_rd(0, 32'h4200_00AB, "R4 chained data error keeps fields");
    repeat (3) @(negedge clk);
    expect_rd(0, 32'h4200_00AB, "R4 chained state held");

    erl = 0;
    cache_evt(1, 0, 0, 1, 12'h7FF);
    expect_rd(0, 32'h8800_07FF, "R5 no chain with error level 0");
    erl = 1;
    cache_evt(1, 1, 0, 0, 12'h010);
    expect_rd(0, 32'hC000_0010, "R5 no chain after data reference");

    erl = 0;
    exc_evt(32'h8000_1000, 0, 32'h8000_0FFC);
    expect_rd(1, 32'h8000_1000, "R6 faulting pc loaded");
    exc_evt(32'h8000_2004, 1, 32'h8000_2000);
    expect_rd(1, 32'h8000_2000, "R7 delay slot loads branch");
    erl = 1;
    exc_evt(32'h1234_5678, 0, 32'h0);
    repeat (2) @(negedge clk);
    expect_rd(1, 32'h8000_2000, "R8 frozen while error level set");
    sw_write(1, 32'hDEAD_BEEC);
    expect_rd(1, 32'hDEAD_BEEC, "R9 software write with error level set");

    erl = 0;
    @(negedge clk);
    reg_we = 1; reg_sel = 0; reg_wdata = 32'hFFFF_FFFF;
    cerr_valid = 1; cerr_is_data = 0; cerr_data_fld = 1; cerr_index = 12'h321;
    @(negedge clk);
    reg_we = 0; cerr_valid = 0; cerr_data_fld = 0;
    expect_rd(0, 32'h4000_0321, "R10 capture beats write on status");

    @(negedge clk);
    reg_we = 1; reg_sel = 1; reg_wdata = 32'h1111_1111;
    exc_valid = 1; exc_pc = 32'h0040_0000; exc_in_delay = 0;
    @(negedge clk);
    reg_we = 0; exc_valid = 0;
    expect_rd(1, 32'h0040_0000, "R10 capture beats write on return address");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule